// File: doc/BRIEF.md
# Multi-Channel PWM with Deferred Update

This block is a pulse-width modulator with several independent channels. Each channel has a prescaler, a period count and a high-time count. Software writes these values into shadow registers through a simple single-cycle register port. The values act on the output only when the channel's enable bit goes from 0 to 1. A per-channel smooth bit chooses when that transfer happens. If smooth is clear, the new values load at once and the channel's counters restart. If smooth is set, a pending flag is raised and the values load at the next period boundary, so no period is cut short.

While the enable bit is low, the smooth bit also sets what the channel drives. With smooth set, the channel keeps running from its last loaded settings. With smooth clear, the channel holds a constant high level. A per-channel polarity bit can invert the level. A per-channel type bit picks push-pull drive or open-drain emulation. In open-drain mode the data pin stays low and the output-enable is released when the level is high.

A zero high-time is the way to stop a channel's output completely.

Top module: `pwm_multi`

## Requirements
- R1: A channel's counter advances once every (prescale+1) clock cycles. It counts 0 to period-1 and then wraps. The raw level is high while the counter is below the duty count, so one period lasts period ticks and the high time lasts duty ticks.
- R2: Writes to a channel's prescale, period or duty shadow register leave its output unchanged until that channel's enable bit rises.
- R3: When enable rises with smooth clear, the shadow values load in the first cycle after the control write. The prescaler and counter restart from zero.
- R4: When enable rises with smooth set, the pending flag of that channel sets. The shadow values then load at the first period boundary at or after the rise, and the flag clears. The flags are read as bits [N_CH-1:0] at address 1; writes to that address are ignored.
- R5: While enable is low and smooth is set, the channel continues the waveform of its last loaded settings.
- R6: While enable is low and smooth is clear, the level is held constant high, before polarity and type are applied.
- R7: Once loaded, a duty count of 0 gives a constant low level. A duty count at or above the period count gives a constant high level. A period count of 0 gives a constant low level.
- R8: Polarity bit 1 passes the level unchanged; polarity bit 0 inverts it.
- R9: Type bit 1 (push-pull) drives the level on the data output with the output-enable asserted. Type bit 0 (open drain) holds the data output low and asserts the output-enable only when the level is low.
- R10: After reset, the control register reads 0x0F0F0F00 (smooth, push-pull and normal polarity set, enable clear). All shadow and loaded values are zero, so every output is low with its output-enable asserted.
- R11: The control register is at address 0. For channel n, enable is bit n, smooth is bit 8+n, type is bit 16+n and polarity is bit 24+n. Channel n's prescale, period and duty shadow registers are at addresses 4+4n, 5+4n and 6+4n, and they read back their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | N_CH | Per-channel data output |
| oe_o | output | N_CH | Per-channel output-enable |

## Verification
The bench builds the block with its default parameters: four channels, a 3-bit prescaler and 24-bit counts. It programs periods of at most twelve ticks and draws prescale values across the full 0 to 7 range. This keeps each deferred load within about a hundred cycles, so smooth swaps land at every phase of the old period, including the case where the rise falls exactly on a boundary. With four channels, each channel's control bits can be toggled while the other channels keep running untouched.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CTRL_W   = 32;
  localparam int EN_OFS   = 0;
  localparam int SM_OFS   = 8;
  localparam int TY_OFS   = 16;
  localparam int PO_OFS   = 24;
  localparam int A_CTRL   = 0;
  localparam int A_PEND   = 1;
  localparam int A_CH_BASE = 4;

  typedef enum logic [1:0] {
    F_PRE  = 2'd0,
    F_PER  = 2'd1,
    F_DUTY = 2'd2,
    F_RSV  = 2'd3
  } field_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int PRE_W  = 3,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CTRL_W-1:0]           wdata_i,
  output logic [CTRL_W-1:0]           rdata_o,
  input  logic [N_CH-1:0]             pend_i,
  output logic [CTRL_W-1:0]           ctrl_o,
  output logic [N_CH-1:0][PRE_W-1:0]  pre_o,
  output logic [N_CH-1:0][CNT_W-1:0]  per_o,
  output logic [N_CH-1:0][CNT_W-1:0]  duty_o
);
  function automatic logic [CTRL_W-1:0] lane_bits(input int ofs);
    logic [CTRL_W-1:0] r;
    r = '0;
    for (int n = 0; n < N_CH; n++) r[ofs+n] = 1'b1;
    return r;
  endfunction

  localparam logic [CTRL_W-1:0] CTRL_RST  = lane_bits(SM_OFS) | lane_bits(TY_OFS) | lane_bits(PO_OFS);
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_RST | lane_bits(EN_OFS);

  logic [CTRL_W-1:0]          ctrl_q;
  logic [N_CH-1:0][PRE_W-1:0] pre_q;
  logic [N_CH-1:0][CNT_W-1:0] per_q;
  logic [N_CH-1:0][CNT_W-1:0] duty_q;
  logic [N_CH-1:0]            ch_hit;
  field_e                     fld;
  logic                       ctrl_hit;
  logic                       pend_hit;

  assign fld      = field_e'(addr_i[1:0]);
  assign ctrl_hit = (addr_i == ADDR_W'(A_CTRL));
  assign pend_hit = (addr_i == ADDR_W'(A_PEND));

  always_comb begin
    for (int n = 0; n < N_CH; n++)
      ch_hit[n] = (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(A_CH_BASE/4 + n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      pre_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      if (ctrl_hit) ctrl_q <= wdata_i & CTRL_MASK;
      for (int n = 0; n < N_CH; n++) begin
        if (ch_hit[n]) begin
          case (fld)
            F_PRE:   pre_q[n]  <= wdata_i[PRE_W-1:0];
            F_PER:   per_q[n]  <= wdata_i[CNT_W-1:0];
            F_DUTY:  duty_q[n] <= wdata_i[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) rdata_o = ctrl_q;
    else if (pend_hit) rdata_o[N_CH-1:0] = pend_i;
    else begin
      for (int n = 0; n < N_CH; n++) begin
        if (ch_hit[n]) begin
          case (fld)
            F_PRE:   rdata_o = {{(CTRL_W-PRE_W){1'b0}}, pre_q[n]};
            F_PER:   rdata_o = {{(CTRL_W-CNT_W){1'b0}}, per_q[n]};
            F_DUTY:  rdata_o = {{(CTRL_W-CNT_W){1'b0}}, duty_q[n]};
            default: rdata_o = '0;
          endcase
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign pre_o  = pre_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PRE_W = 3,
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smooth_i,
  input  logic [PRE_W-1:0] sh_pre_i,
  input  logic [CNT_W-1:0] sh_per_i,
  input  logic [CNT_W-1:0] sh_duty_i,
  output logic             pend_o,
  output logic             lvl_o
);
  logic             en_q;
  logic             pend_q;
  logic [PRE_W-1:0] act_pre, pc_q;
  logic [CNT_W-1:0] act_per, act_duty, cnt_q;
  logic             rise, tick, per_end, load, raw;

  assign rise    = en_i & ~en_q;
  assign tick    = (pc_q == act_pre);
  assign per_end = tick & ((act_per == '0) | (cnt_q == act_per - CNT_W'(1)));
  // a smooth rise that lands on a boundary loads in the same cycle
  assign load    = (rise & ~smooth_i) | ((pend_q | (rise & smooth_i)) & per_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      act_pre  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      pc_q     <= '0;
      cnt_q    <= '0;
    end else begin
      en_q <= en_i;
      if (load) begin
        act_pre  <= sh_pre_i;
        act_per  <= sh_per_i;
        act_duty <= sh_duty_i;
        pc_q     <= '0;
        cnt_q    <= '0;
        pend_q   <= 1'b0;
      end else begin
        if (rise & smooth_i) pend_q <= 1'b1;
        if (tick) begin
          pc_q  <= '0;
          cnt_q <= per_end ? '0 : cnt_q + CNT_W'(1);
        end else begin
          pc_q <= pc_q + PRE_W'(1);
        end
      end
    end
  end

  assign raw    = (act_per != '0) && (cnt_q < act_duty);
  assign lvl_o  = (~en_i & ~smooth_i) ? 1'b1 : raw;
  assign pend_o = pend_q;
endmodule

// File: rtl/pwm_drive.sv
module pwm_drive (
  input  logic lvl_i,
  input  logic pol_i,
  input  logic type_i,
  output logic pwm_o,
  output logic oe_o
);
  logic lvl;

  assign lvl   = pol_i ? lvl_i : ~lvl_i;
  assign pwm_o = type_i ? lvl : 1'b0;
  assign oe_o  = type_i ? 1'b1 : ~lvl;
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int PRE_W  = 3,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   oe_o
);
  logic [CTRL_W-1:0]          ctrl_q;
  logic [N_CH-1:0]            pend;
  logic [N_CH-1:0]            lvl;
  logic [N_CH-1:0][PRE_W-1:0] sh_pre;
  logic [N_CH-1:0][CNT_W-1:0] sh_per;
  logic [N_CH-1:0][CNT_W-1:0] sh_duty;

  pwm_regs #(
    .N_CH(N_CH), .PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pend_i  (pend),
    .ctrl_o  (ctrl_q),
    .pre_o   (sh_pre),
    .per_o   (sh_per),
    .duty_o  (sh_duty)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pwm_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ctrl_q[EN_OFS+i]),
      .smooth_i  (ctrl_q[SM_OFS+i]),
      .sh_pre_i  (sh_pre[i]),
      .sh_per_i  (sh_per[i]),
      .sh_duty_i (sh_duty[i]),
      .pend_o    (pend[i]),
      .lvl_o     (lvl[i])
    );

    pwm_drive u_drive (
      .lvl_i  (lvl[i]),
      .pol_i  (ctrl_q[PO_OFS+i]),
      .type_i (ctrl_q[TY_OFS+i]),
      .pwm_o  (pwm_o[i]),
      .oe_o   (oe_o[i])
    );
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [N_CH-1:0]   pend_i,
  input logic [N_CH-1:0]   pwm_i,
  input logic [N_CH-1:0]   oe_i
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    assert_pend_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[i]) |-> $past(ctrl_i[EN_OFS+i]) && $past(ctrl_i[SM_OFS+i])
                           && !$past(ctrl_i[EN_OFS+i], 2))
      else $error("pending flag set without a smooth enable rise, ch %0d", i);

    assert_idle_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_i[EN_OFS+i] && !ctrl_i[SM_OFS+i] && ctrl_i[TY_OFS+i] && ctrl_i[PO_OFS+i])
        |-> pwm_i[i])
      else $error("idle non-smooth channel not high, ch %0d", i);

    assert_od_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_i[TY_OFS+i] |-> !pwm_i[i])
      else $error("open-drain channel drives high, ch %0d", i);

    assert_pp_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i[TY_OFS+i] |-> oe_i[i])
      else $error("push-pull channel released, ch %0d", i);
  end
endmodule

bind pwm_multi pwm_multi_chk #(.N_CH(N_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ctrl_i (ctrl_q),
  .pend_i (pend),
  .pwm_i  (pwm_o),
  .oe_i   (oe_o)
);

// File: tb/tb_pwm_multi.sv
`timescale 1ns/1ps
module tb_pwm_multi;
  localparam int N_CH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N_CH-1:0] pwm, oe;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] ctrl_val = 32'h0F0F0F00;
  int cur_pre[N_CH], cur_per[N_CH], cur_duty[N_CH], base[N_CH];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_multi dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm), .oe_o(oe)
  );

  function automatic bit exp_raw(int k, int pre, int per, int duty);
    if (per == 0) return 1'b0;
    return ((k / (pre + 1)) % per) < duty;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    we = 1'b0; addr = 5'(a);
    #1 d = rdata;
  endtask

  task automatic set_ctrl(int ch, bit en, bit sm, bit ty, bit po);
    ctrl_val[ch] = en; ctrl_val[8+ch] = sm; ctrl_val[16+ch] = ty; ctrl_val[24+ch] = po;
    wr(0, ctrl_val);
  endtask

  task automatic wr_shadow(int ch, int pre, int per, int duty);
    wr(4 + 4*ch, 32'(pre));
    wr(5 + 4*ch, 32'(per));
    wr(6 + 4*ch, 32'(duty));
  endtask

  // immediate load (R3): enable low then high with smooth clear
  task automatic load_now(int ch, int pre, int per, int duty);
    wr_shadow(ch, pre, per, duty);
    set_ctrl(ch, 0, 0, 1, 1);
    set_ctrl(ch, 1, 0, 1, 1);
    @(negedge clk);
    base[ch] = cyc;
    cur_pre[ch] = pre; cur_per[ch] = per; cur_duty[ch] = duty;
  endtask

  task automatic chk_wave(int ch, int n, bit inv, bit od, string req);
    for (int j = 0; j < n; j++) begin
      bit lv, ep, eo;
      lv = exp_raw(cyc - base[ch], cur_pre[ch], cur_per[ch], cur_duty[ch]) ^ inv;
      ep = od ? 1'b0 : lv;
      eo = od ? ~lv : 1'b1;
      check(pwm[ch] == ep && oe[ch] == eo, req, $sformatf("ch%0d k=%0d {oe,pwm}", ch, cyc - base[ch]),
            {oe[ch], pwm[ch]}, {eo, ep});
      @(negedge clk);
    end
  endtask

  task automatic smooth_swap(int ch, int pre, int per, int duty);
    int b0, p0, q0, d0, l0, k1, nb;
    logic [31:0] d;
    b0 = base[ch]; p0 = cur_pre[ch]; q0 = cur_per[ch]; d0 = cur_duty[ch];
    l0 = q0 * (p0 + 1);
    wr_shadow(ch, pre, per, duty);
    set_ctrl(ch, 0, 1, 1, 1);
    set_ctrl(ch, 1, 1, 1, 1);
    @(negedge clk);
    k1 = cyc - b0;
    nb = b0 + ((k1 + l0 - 1) / l0) * l0;
    rd(1, d);
    check(d[ch] == (cyc < nb), "R4", "pending after smooth rise", d[ch], int'(cyc < nb));
    while (cyc < nb) begin
      bit e;
      e = exp_raw(cyc - b0, p0, q0, d0);
      check(pwm[ch] == e, "R4", "old wave kept until boundary", pwm[ch], e);
      @(negedge clk);
    end
    base[ch] = nb;
    cur_pre[ch] = pre; cur_per[ch] = per; cur_duty[ch] = duty;
    chk_wave(ch, 2 * per * (pre + 1), 0, 0, "R4");
    rd(1, d);
    check(d[ch] == 1'b0, "R4", "pending cleared", d[ch], 0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(0, d);
    check(d == 32'h0F0F0F00, "R10", "control reset", d, 32'h0F0F0F00);
    rd(1, d);
    check(d == 0, "R10", "pending reset", d, 0);
    rd(5, d);
    check(d == 0, "R10", "period shadow reset", d, 0);
    check(pwm == 4'h0 && oe == 4'hF, "R10", "outputs at reset", {oe, pwm}, 8'hF0);

    // R11 register map readback; write to pending address ignored
    wr(13, 32'h123456);
    rd(13, d);
    check(d == 32'h123456, "R11", "ch2 period readback", d, 32'h123456);
    wr(4, 32'hFF);
    rd(4, d);
    check(d == 32'h7, "R11", "prescale field width", d, 7);
    wr(1, 32'hF);
    rd(1, d);
    check(d == 0, "R4", "pending not writable", d, 0);
    wr(0, ctrl_val);

    // R1 R3 random immediate loads on every channel
    for (int it = 0; it < 12; it++) begin
      int ch, pre, per, duty;
      ch = it % N_CH;
      pre = $urandom % 8;
      per = 1 + $urandom % 12;
      duty = $urandom % (per + 3);
      load_now(ch, pre, per, duty);
      chk_wave(ch, 2 * per * (pre + 1) + 3, 0, 0, "R1_R3");
    end

    // R2 shadow writes without a rise leave ch0 untouched
    wr_shadow(0, 5, 3, 1);
    chk_wave(0, 40, 0, 0, "R2");

    // R5 enable low, smooth set: waveform continues
    set_ctrl(0, 0, 1, 1, 1);
    chk_wave(0, 40, 0, 0, "R5");

    // R6 enable low, smooth clear: constant high
    set_ctrl(0, 0, 0, 1, 1);
    for (int j = 0; j < 20; j++) begin
      check(pwm[0] == 1'b1, "R6", "idle high", pwm[0], 1);
      @(negedge clk);
    end

    // R4 deferred loads from a known running state
    load_now(1, 2, 5, 2);
    repeat (7) @(negedge clk);
    smooth_swap(1, 1, 4, 3);
    load_now(2, 0, 7, 3);
    smooth_swap(2, 3, 3, 1);
    for (int it = 0; it < 4; it++) begin
      repeat ($urandom % 9) @(negedge clk);
      smooth_swap(1 + it % 2, $urandom % 8, 1 + $urandom % 10, $urandom % 11);
    end

    // R7 corner counts on ch3
    load_now(3, 1, 6, 0);
    for (int j = 0; j < 30; j++) begin
      check(pwm[3] == 1'b0, "R7", "duty 0 low", pwm[3], 0); @(negedge clk);
    end
    load_now(3, 0, 4, 4);
    for (int j = 0; j < 30; j++) begin
      check(pwm[3] == 1'b1, "R7", "duty=period high", pwm[3], 1); @(negedge clk);
    end
    load_now(3, 2, 3, 9);
    for (int j = 0; j < 30; j++) begin
      check(pwm[3] == 1'b1, "R7", "duty>period high", pwm[3], 1); @(negedge clk);
    end
    load_now(3, 0, 0, 5);
    for (int j = 0; j < 30; j++) begin
      check(pwm[3] == 1'b0, "R7", "period 0 low", pwm[3], 0); @(negedge clk);
    end

    // R8 polarity inversion and R9 open drain on a running ch3
    load_now(3, 1, 5, 2);
    set_ctrl(3, 1, 0, 1, 0);
    chk_wave(3, 30, 1, 0, "R8");
    set_ctrl(3, 1, 0, 0, 1);
    chk_wave(3, 30, 0, 1, "R9");
    set_ctrl(3, 1, 0, 0, 0);
    chk_wave(3, 30, 1, 1, "R9");
    set_ctrl(3, 1, 0, 1, 1);
    chk_wave(3, 20, 0, 0, "R8");

    done = 1;
    finish_up();
  end
endmodule